// File: doc/BRIEF.md
# Shared Host Bus Front End for Commands and Audio Samples

This block connects an 8-bit host bus, driven by asynchronous active-low strobes, to two paths inside a device. The first path is for commands and status. The second path holds audio samples in two channels. A data/command select line chooses the path for each access.

On the command path:
- A host write hands one command byte to the command processor for one cycle.
- The block then holds a busy handshake low until the processor reports that it is done.
- A host read returns a status byte. That byte is captured only when a status-read command is accepted.

On the audio path, the host writes bytes into a small FIFO for the left or right channel and reads them back from it. The empty, half and full flags of the channel picked by the channel select line are driven to the flag pins. The bus is split into an input, an output and an output enable, so the pad ring can build the tri-state driver.

The strobes are sampled by the block clock. The host must hold chip select, data/command select, channel select and the data byte steady from the falling edge of a strobe until one clock after its rising edge.

Top module: `hostbus_front`

## Requirements
- R1: A rising edge of `wr_n` with `cs_n` low, `dc_sel` low and `busy_n` high is a command write. In the next cycle, `cmd_valid` is high for exactly one cycle with `cmd_byte` equal to the bus byte, and `busy_n` goes low. `busy_n` stays low until the cycle after `cmd_done` is sampled high.
- R2: A command write that arrives while `busy_n` is low produces no `cmd_valid` pulse and does not change `busy_n`.
- R3: A command write with `cs_n` high is ignored: no `cmd_valid` pulse and no change to `busy_n`.
- R4: While `dc_sel` is low, `cs_n` is low and `rd_n` is low, `bus_out` carries the latched status byte and `bus_oe` is high.
- R5: The latched status byte resets to 0x00. It loads from `status_in` only when an accepted command byte equals `STAT_CMD` (default 0x5A), and it holds its value at all other times.
- R6: A rising edge of `wr_n` with `dc_sel` high pushes the bus byte into the FIFO picked by `ch_sel` (0 = left, 1 = right). This happens whatever the level of `cs_n`.
- R7: While `dc_sel` is high, `cs_n` is low and `rd_n` is low, `bus_out` shows the oldest byte of the selected FIFO. The rising edge of `rd_n` under the same selection pops that byte.
- R8: Reading an empty FIFO returns 0x00 and leaves that FIFO unchanged.
- R9: A write to a full FIFO (`DEPTH` entries, default 8) is dropped, and the FIFO contents do not change.
- R10: `flag_empty`, `flag_half` and `flag_full` describe the FIFO picked by `ch_sel`. They mean, in order: 0 entries; at least `DEPTH/2` entries; exactly `DEPTH` entries.
- R11: `bus_oe` is low whenever `rd_n` is high or `cs_n` is high. A read strobe with `cs_n` high pops nothing.
- R12: An access to one channel never changes the contents or the flags of the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| dc_sel | input | 1 | 0 = command/status, 1 = audio samples |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| ch_sel | input | 1 | Audio channel, 0 = left, 1 = right |
| bus_in | input | 8 | Byte from the host bus |
| bus_out | output | 8 | Byte to the host bus |
| bus_oe | output | 1 | Drive enable for the bus pads |
| status_in | input | 8 | Live status from the device core |
| cmd_done | input | 1 | Command processor finished; releases busy |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_byte | output | 8 | Accepted command byte |
| busy_n | output | 1 | Low while a command is being processed |
| flag_empty | output | 1 | Selected FIFO is empty |
| flag_half | output | 1 | Selected FIFO is at least half full |
| flag_full | output | 1 | Selected FIFO is full |

## Verification
Some properties are checked by assertions on every cycle:
- A FIFO never holds more than its depth.
- A push into a full FIFO or a pop from an empty one leaves the occupancy unchanged.
- A command pulse always comes with busy going low, and only when busy was high before.
- The status byte changes only together with a status-read command.
- A full flag implies a half flag and no empty flag.

Other behaviour can only be shown by the bench's scenarios, with its reference model checked on every clock:
- Command writes are dropped when chip select is high or busy is low.
- Audio writes are accepted with chip select high.
- Data comes back in first-in, first-out order.
- Empty reads return zero.
- The two channels stay independent.

// File: rtl/hb_pkg.sv
// Shared definitions for the host bus front end.
// Assumes an 8-bit host bus and two audio channels.
package hb_pkg;
    localparam int HB_DATA_W    = 8;
    localparam int HB_CHANNELS  = 2;
    localparam int HB_DEPTH     = 8;
    localparam logic [7:0] HB_STAT_CMD = 8'h5A;

    typedef enum logic {
        HB_CH_LEFT  = 1'b0,
        HB_CH_RIGHT = 1'b1
    } hb_chan_e;
endpackage

// File: rtl/hb_edge.sv
// Rising-edge detector for an active-low strobe that is already synchronous to clk.
// Assumes the strobe idles high; the reset state is high, so no false edge is seen after reset.
module hb_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic rise
);
    logic prev_q;

    // Keep the strobe level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= strobe_n;
    end

    assign rise = strobe_n & ~prev_q;
endmodule

// File: rtl/hb_fifo.sv
// One-channel sample FIFO: a push while full is dropped, a pop while empty does nothing.
// Assumes DEPTH is a power of two, so the pointers wrap on their own.
module hb_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              half,
    output logic              full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_C  = CW'(DEPTH / 2);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic [CW-1:0]     count;
    logic              do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == DEPTH_C);
    assign half    = (count >= HALF_C);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign head    = mem[rptr];

    // Storage write; memory needs no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_C);
    assert_full_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == DEPTH_C));
    assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> ($stable(rptr) && count == '0));
endmodule

// File: rtl/hb_cmd_port.sv
// Command handoff and status latch. An accepted command strobes cmd_valid
// and drops busy until cmd_done arrives; the status-read command captures status_in.
// Assumes the caller qualifies wr_rise with chip select and command mode.
module hb_cmd_port #(
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  STAT_CMD = 8'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              cmd_done,
    input  logic [DATA_W-1:0] status_in,
    output logic              cmd_valid,
    output logic [DATA_W-1:0] cmd_byte,
    output logic              busy_n,
    output logic [DATA_W-1:0] status_q
);
    logic accept;
    assign accept = wr_cmd & busy_n;

    // Command strobe, byte capture and busy handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_byte  <= '0;
            busy_n    <= 1'b1;
        end else begin
            cmd_valid <= accept;
            if (accept)        cmd_byte <= wr_byte;
            if (accept)        busy_n   <= 1'b0;
            else if (cmd_done) busy_n   <= 1'b1;
        end
    end

    // Status snapshot, taken only on the status-read command.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    status_q <= '0;
        else if (accept && wr_byte == DATA_W'(STAT_CMD)) status_q <= status_in;
    end

    assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !busy_n);
    assert_busy_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(busy_n));
    assert_status_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status_q) |-> (cmd_valid && cmd_byte == DATA_W'(STAT_CMD)));
endmodule

// File: rtl/hostbus_front.sv
// Top of the shared host bus front end. It splits host accesses between the
// command/status port and two per-channel sample FIFOs, and drives the bus output and the flags.
// Assumes the bus control inputs are synchronous to clk and stay stable around each strobe edge.
module hostbus_front
    import hb_pkg::*;
#(
    parameter int          DATA_W   = HB_DATA_W,
    parameter int          DEPTH    = HB_DEPTH,
    parameter logic [7:0]  STAT_CMD = HB_STAT_CMD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              dc_sel,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              ch_sel,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] status_in,
    input  logic              cmd_done,
    output logic              cmd_valid,
    output logic [DATA_W-1:0] cmd_byte,
    output logic              busy_n,
    output logic              flag_empty,
    output logic              flag_half,
    output logic              flag_full
);
    localparam int NCH = HB_CHANNELS;

    logic              wr_rise, rd_rise;
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] ch_head  [NCH];
    logic [NCH-1:0]    ch_empty, ch_half, ch_full;
    hb_chan_e          chan;

    assign chan = hb_chan_e'(ch_sel);

    hb_edge u_wr_edge (.clk(clk), .rst_n(rst_n), .strobe_n(wr_n), .rise(wr_rise));
    hb_edge u_rd_edge (.clk(clk), .rst_n(rst_n), .strobe_n(rd_n), .rise(rd_rise));

    hb_cmd_port #(.DATA_W(DATA_W), .STAT_CMD(STAT_CMD)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cmd    (wr_rise & ~cs_n & ~dc_sel),
        .wr_byte   (bus_in),
        .cmd_done  (cmd_done),
        .status_in (status_in),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .busy_n    (busy_n),
        .status_q  (status_q)
    );

    // One FIFO per channel; audio writes do not depend on chip select, audio reads do.
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        hb_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (wr_rise & dc_sel & (int'(chan) == c)),
            .push_data (bus_in),
            .pop       (rd_rise & dc_sel & ~cs_n & (int'(chan) == c)),
            .head      (ch_head[c]),
            .empty     (ch_empty[c]),
            .half      (ch_half[c]),
            .full      (ch_full[c])
        );
    end

    // Bus read mux and flag routing for the selected channel.
    always_comb begin
        bus_oe     = ~rd_n & ~cs_n;
        flag_empty = ch_empty[chan];
        flag_half  = ch_half[chan];
        flag_full  = ch_full[chan];
        if (!dc_sel)              bus_out = status_q;
        else if (ch_empty[chan])  bus_out = '0;
        else                      bus_out = ch_head[chan];
    end

    assert_flag_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flag_full |-> (flag_half && !flag_empty));
    assert_oe_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n || cs_n) |-> !bus_oe);
endmodule

// File: tb/hostbus_front_tb_top.sv
// Bench: drives the bus on falling clock edges, keeps a behavioural model
// (queues and flags), and compares every output against it on every clock.
module hostbus_front_tb_top;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam logic [7:0] STAT = 8'h5A;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, dc_sel = 1'b0, wr_n = 1'b1, rd_n = 1'b1, ch_sel = 1'b0;
    logic [7:0] bus_in = '0, status_in = '0;
    logic cmd_done = 1'b0;
    logic [7:0] bus_out, cmd_byte;
    logic bus_oe, cmd_valid, busy_n, flag_empty, flag_half, flag_full;

    int total = 0, bad = 0;
    bit finished = 0;

    // Model state.
    logic [7:0] q_l[$], q_r[$];
    logic       m_busy_n = 1'b1, m_cmdv = 1'b0;
    logic [7:0] m_cmd = '0, m_stat = '0;

    always #(PERIOD/2) clk = ~clk;

    hostbus_front dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dc_sel(dc_sel), .wr_n(wr_n),
        .rd_n(rd_n), .ch_sel(ch_sel), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .status_in(status_in), .cmd_done(cmd_done),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .busy_n(busy_n),
        .flag_empty(flag_empty), .flag_half(flag_half), .flag_full(flag_full)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    function automatic int qsize(input logic ch);
        return ch ? q_r.size() : q_l.size();
    endfunction

    // Compare with the model shortly after every rising edge.
    always @(posedge clk) begin
        #2;
        if (rst_n && !finished) begin
            int n;
            logic [7:0] exp_bus;
            n = qsize(ch_sel);
            check("R1 R2 R3 busy_n", {7'd0, busy_n}, {7'd0, m_busy_n});
            check("R1 R2 R3 cmd_valid", {7'd0, cmd_valid}, {7'd0, m_cmdv});
            if (m_cmdv) check("R1 cmd_byte", cmd_byte, m_cmd);
            check("R11 bus_oe", {7'd0, bus_oe}, {7'd0, (!rd_n && !cs_n)});
            if (!rd_n && !cs_n) begin
                if (!dc_sel)     exp_bus = m_stat;
                else if (n == 0) exp_bus = 8'h00;
                else             exp_bus = ch_sel ? q_r[0] : q_l[0];
                check(dc_sel ? "R7 R8 R12 sample" : "R4 R5 status", bus_out, exp_bus);
            end
            check("R10 R12 flag_empty", {7'd0, flag_empty}, {7'd0, n == 0});
            check("R10 flag_half", {7'd0, flag_half}, {7'd0, n >= DEPTH/2});
            check("R10 R9 flag_full", {7'd0, flag_full}, {7'd0, n == DEPTH});
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Write strobe; the model applies its effect at the edge that sees the rise.
    task automatic bus_write(input logic dc, input logic cs, input logic ch, input logic [7:0] b);
        @(negedge clk);
        dc_sel = dc; cs_n = cs; ch_sel = ch; bus_in = b; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(posedge clk);
        if (!dc) begin
            if (!cs && m_busy_n) begin
                m_cmdv = 1'b1; m_cmd = b; m_busy_n = 1'b0;
                if (b == STAT) m_stat = status_in;
            end
        end else begin
            if (!ch && q_l.size() < DEPTH) q_l.push_back(b);
            if (ch && q_r.size() < DEPTH)  q_r.push_back(b);
        end
        @(posedge clk);
        m_cmdv = 1'b0;
    endtask

    // Read strobe; a rise with audio mode and chip select pops the model queue.
    task automatic bus_read(input logic dc, input logic cs, input logic ch);
        @(negedge clk);
        dc_sel = dc; cs_n = cs; ch_sel = ch; rd_n = 1'b0;
        @(negedge clk);
        rd_n = 1'b1;
        @(posedge clk);
        if (dc && !cs) begin
            if (!ch && q_l.size() > 0) void'(q_l.pop_front());
            if (ch && q_r.size() > 0)  void'(q_r.pop_front());
        end
    endtask

    task automatic finish_cmd();
        @(negedge clk);
        cmd_done = 1'b1;
        @(posedge clk);
        m_busy_n = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
    endtask

    initial begin
        #(200000 * PERIOD);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state of busy, strobe, flags and bus (R1 R10 R11).
        @(negedge clk);
        check("R1 reset busy_n", {7'd0, busy_n}, 8'd1);
        check("R10 reset flags", {5'd0, flag_empty, flag_half, flag_full}, 8'b100);
        check("R11 reset bus_oe", {7'd0, bus_oe}, 8'd0);

        // R1: command accepted; R2: second while busy ignored.
        bus_write(1'b0, 1'b0, 1'b0, 8'h11);
        bus_write(1'b0, 1'b0, 1'b0, 8'h22);
        idle(2);
        finish_cmd();
        // R3: chip select high drops the command.
        bus_write(1'b0, 1'b1, 1'b0, 8'h33);
        idle(1);

        // R4 R5: status is not refreshed without the status command.
        status_in = 8'hC3;
        bus_read(1'b0, 1'b0, 1'b0);
        bus_write(1'b0, 1'b0, 1'b0, STAT);
        status_in = 8'h77;
        finish_cmd();
        bus_read(1'b0, 1'b0, 1'b0);
        bus_write(1'b0, 1'b0, 1'b0, 8'h44);
        finish_cmd();
        bus_read(1'b0, 1'b0, 1'b0);

        // R6: audio writes with chip select high still land; R12 channel independence.
        bus_write(1'b1, 1'b1, 1'b0, 8'hA1);
        bus_write(1'b1, 1'b1, 1'b0, 8'hA2);
        bus_write(1'b1, 1'b0, 1'b0, 8'hA3);
        bus_write(1'b1, 1'b0, 1'b1, 8'hB1);
        // R7: in-order reads; R11: read with chip select high pops nothing.
        bus_read(1'b1, 1'b1, 1'b0);
        bus_read(1'b1, 1'b0, 1'b0);
        bus_read(1'b1, 1'b0, 1'b1);
        // R8: empty right channel reads zero.
        bus_read(1'b1, 1'b0, 1'b1);
        bus_read(1'b1, 1'b0, 1'b1);

        // R9: fill left past its depth; extras are dropped.
        for (int i = 0; i < DEPTH + 2; i++) bus_write(1'b1, 1'b0, 1'b0, 8'(8'hC0 + i));
        check("R9 full after overfill", {7'd0, flag_full}, 8'd1);
        bus_read(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < DEPTH + 2; i++) bus_read(1'b1, 1'b0, 1'b0);
        check("R8 drained left empty", {7'd0, flag_empty}, 8'd1);

        idle(2);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule